// File: doc/BRIEF.md
# Mains-Locked Fractional Rate Converter

This block turns a slow reference pulse train, typically derived from the mains (for example 120 pulses per second), into an event strobe at another rate (for example 100 per second). Over the long term the output count matches the ideal ratio exactly, and there is no drift. Each reference pulse opens a burst. The burst contains a fixed number of synthetic sub-pulses, spaced by a free-running tick timer. Each sub-pulse adds the output rate to an error accumulator. When the accumulator reaches the sub-pulse rate, that rate is taken off it and an event is emitted.

The timer is not cleared when it is due. It is reduced by the sub-pulse interval, so any excess ticks carry into the next interval. The accumulator is cleared only at reset and keeps its remainder from one burst to the next. The rates, the burst length and the interval are parameters, so other ratios such as 50 to 60 or 60 to 50 need only new constants. A reference pulse that arrives while a burst is still running is reported as an overrun, and it restarts the burst.

Top module: `rate_converter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `sub_o`, `event_o` and `overrun_o` are 0, and the accumulator holds 0.
- R2: A `ref_pulse` high on a clock edge resets the timer to 0 and raises `sub_o` for one cycle after that edge. That sub-pulse is the first of the burst.
- R3: Within a burst, the timer advances by one on each edge where `tick_en` is high. A sub-pulse is issued on the edge after the timer has reached `PERIOD`. At that edge the timer becomes `timer - PERIOD + tick_en`, so excess ticks are kept.
- R4: A burst that is not interrupted gives exactly `SUBS` sub-pulses. After that no sub-pulse occurs, whatever `tick_en` does, until the next `ref_pulse`.
- R5: Each sub-pulse adds `OUT_RATE` to the accumulator. If the sum is at least `SUB_RATE`, `SUB_RATE` is subtracted and `event_o` is high in the same cycle as that `sub_o`. `event_o` is never high without `sub_o`, so there is at most one event per sub-pulse (this needs `OUT_RATE <= SUB_RATE`).
- R6: The accumulator is not cleared between bursts. After N sub-pulses from reset, the number of events equals floor(N * OUT_RATE / SUB_RATE).
- R7: A `ref_pulse` that arrives while sub-pulses of the current burst are still pending raises `overrun_o` for one cycle, together with `sub_o`, and restarts the burst with `SUBS` sub-pulses.
- R8: A `ref_pulse` that arrives in the same cycle as a due sub-pulse gives one sub-pulse and one accumulator step, not two.
- R9: On an edge where `tick_en` is low, the timer does not advance. A burst therefore stretches in proportion to the missing ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer tick enable, one tick per high cycle |
| ref_pulse | input | 1 | Single-cycle reference pulse, mains-derived |
| sub_o | output | 1 | One-cycle strobe for each synthetic sub-pulse |
| event_o | output | 1 | One-cycle output event strobe |
| overrun_o | output | 1 | One-cycle flag: a reference pulse interrupted a running burst |

## Verification
Two functions can coincide: the timer-driven sub-pulse and a burst restart caused by a reference pulse. The bench follows the timer in its own model and drives `ref_pulse` on the exact edge where a sub-pulse falls due. The expected result is a single sub-pulse, a single accumulator step, an overrun flag and a fresh burst of full length. All outputs are compared with the model on every cycle. The final event total is also checked against the exact rational count of the sub-pulses seen.

// File: rtl/rate_converter.sv
module rate_converter #(
  parameter int SUBS     = 10,
  parameter int PERIOD   = 104,
  parameter int OUT_RATE = 100,
  parameter int SUB_RATE = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic ref_pulse,
  output logic sub_o,
  output logic event_o,
  output logic overrun_o
);
  localparam int TW = $clog2(PERIOD + 2) + 1;
  localparam int AW = $clog2(SUB_RATE + OUT_RATE + 1);
  localparam int CW = $clog2(SUBS + 1);

  logic [TW-1:0] timer;
  logic [AW-1:0] acc;
  logic [CW-1:0] left;

  wire          busy    = left != '0;
  wire          due     = busy && (timer >= TW'(PERIOD));
  wire          fire    = ref_pulse || due;
  wire [AW-1:0] acc_sum = acc + AW'(OUT_RATE);
  wire          wrap    = acc_sum >= AW'(SUB_RATE);
  wire [TW-1:0] tick_w  = {{(TW-1){1'b0}}, tick_en};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer     <= '0;
      acc       <= '0;
      left      <= '0;
      sub_o     <= 1'b0;
      event_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      sub_o     <= fire;
      event_o   <= fire && wrap;
      overrun_o <= ref_pulse && busy;
      if (fire)
        acc <= wrap ? acc_sum - AW'(SUB_RATE) : acc_sum;
      if (ref_pulse) begin
        left  <= CW'(SUBS - 1);
        timer <= '0;
      end else if (due) begin
        left  <= left - 1'b1;
        timer <= timer - TW'(PERIOD) + tick_w;
      end else if (busy) begin
        timer <= timer + tick_w;
      end
    end
  end
endmodule

module rate_converter_chk #(
  parameter int PERIOD = 104,
  parameter int TW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          ref_pulse,
  input logic          sub_o,
  input logic          event_o,
  input logic          overrun_o,
  input logic          busy,
  input logic [TW-1:0] timer
);
  p_ref_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> sub_o);
  p_event_with_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> sub_o);
  p_overrun_with_sub_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> sub_o);
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ref_pulse) |=> !sub_o);
  p_tick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ref_pulse && !tick_en && timer < TW'(PERIOD)) |=> $stable(timer));
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!sub_o && !event_o && !overrun_o));
endmodule

bind rate_converter rate_converter_chk #(.PERIOD(PERIOD), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ref_pulse(ref_pulse),
  .sub_o(sub_o), .event_o(event_o), .overrun_o(overrun_o),
  .busy(busy), .timer(timer)
);

// File: tb/rate_converter_test.sv
module rate_converter_test;
  localparam int SUBS = 10, PERIOD = 104, OUT_RATE = 100, SUB_RATE = 1200;

  logic clk = 0, rst_n = 0, tick_en = 0, ref_pulse = 0;
  logic sub_o, event_o, overrun_o;
  int checks = 0, errors = 0;
  int m_timer = 0, m_acc = 0, m_left = 0;
  bit e_sub = 0, e_ev = 0, e_ovr = 0;
  int n_sub = 0, n_ev = 0, burst_subs = 0;
  bit tick_rand = 0;

  always #4 clk = ~clk;

  rate_converter uut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ref_pulse(ref_pulse),
                      .sub_o(sub_o), .event_o(event_o), .overrun_o(overrun_o));

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_timer = 0; m_acc = 0; m_left = 0; e_sub = 0; e_ev = 0; e_ovr = 0;
    end else begin
      bit due;
      due = (m_left > 0) && (m_timer >= PERIOD);
      e_sub = ref_pulse || due;
      e_ovr = ref_pulse && (m_left > 0);
      e_ev = 0;
      if (e_sub) begin
        m_acc = m_acc + OUT_RATE;
        if (m_acc >= SUB_RATE) begin m_acc = m_acc - SUB_RATE; e_ev = 1; end
      end
      if (ref_pulse) begin m_left = SUBS - 1; m_timer = 0; end
      else if (due) begin m_left = m_left - 1; m_timer = m_timer - PERIOD + int'(tick_en); end
      else if (m_left > 0) m_timer = m_timer + int'(tick_en);
    end
  end

  task automatic chk(string req, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk("R2/R3/R4/R8", "sub_o", sub_o, e_sub);
    chk("R5/R6", "event_o", event_o, e_ev);
    chk("R7", "overrun_o", overrun_o, e_ovr);
    if (sub_o) begin n_sub++; burst_subs++; end
    if (event_o) n_ev++;
  end

  always @(negedge clk) tick_en <= tick_rand ? 1'($urandom_range(0, 1)) : 1'b1;

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic pulse_ref;
    @(negedge clk); ref_pulse = 1;
    @(negedge clk); ref_pulse = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired got running exp done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "sub_o in reset", sub_o, 0);
    chk("R1", "event_o in reset", event_o, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1", "overrun_o after reset", overrun_o, 0);

    // R4/R6: regular bursts, full ticks; 12 bursts -> 120 subs -> 10 events
    for (int b = 0; b < 12; b++) begin
      burst_subs = 0;
      pulse_ref();
      repeat (1100) @(negedge clk);
      chk("R4", "subs per burst", burst_subs, SUBS);
    end
    chk("R6", "events after 12 bursts", n_ev, 10);

    // R9: sparse ticks stretch the burst, idle phase gets ticks but no subs
    tick_rand = 1;
    for (int b = 0; b < 6; b++) begin
      burst_subs = 0;
      pulse_ref();
      repeat (2600) @(negedge clk);
      chk("R4", "subs per sparse burst", burst_subs, SUBS);
    end
    tick_rand = 0;

    // R7: overrun mid-burst
    for (int b = 0; b < 4; b++) begin
      pulse_ref();
      repeat (300 + 37 * b) @(negedge clk);
    end
    repeat (1200) @(negedge clk);

    // R8: reference pulse on the exact edge a sub-pulse falls due
    for (int b = 0; b < 3; b++) begin
      pulse_ref();
      repeat (150 + 104 * b) @(negedge clk);
      while (!(m_left > 0 && m_timer >= PERIOD)) @(negedge clk);
      burst_subs = 0;
      ref_pulse = 1;
      @(negedge clk); ref_pulse = 0;
      chk("R8", "overrun on coincident ref", overrun_o, 1);
      repeat (1200) @(negedge clk);
      chk("R8", "single restart burst length", burst_subs, SUBS);
    end

    // R6: long-run exactness over all subs seen
    chk("R6", "total events vs subs", n_ev, (n_sub * OUT_RATE) / SUB_RATE);
    summary();
  end
endmodule